// File: doc/BRIEF.md
# Vector Condition Result Packer

The packer walks a vector of up to sixteen elements, one per clock. For each element it compares a 4-bit condition field against a 4-bit mode pattern, keeping only the bits selected by a 4-bit mask, and so forms a 4-bit match nibble. The nibbles are packed side by side into integer registers held in a small internal register file. A 2-bit source width code sets how many nibbles should share one destination element. A 2-bit destination width code sets the size of that element. When the element is too narrow for the requested count, the extra nibbles spill into the next register.

A request is launched with a one-cycle `start` while the unit is idle. All request inputs, including a snapshot of every condition field, are captured on that edge. `busy` stays high while elements are being processed, and `done` pulses once at the end. A registered read port lets the surrounding logic inspect the register file. Each destination register that the request touches is rewritten as a whole word, so any bit not carrying a nibble ends up zero.

Top module: `cond_pack_unit`

## Requirements
- R1: Bit k of an element's nibble (k = 0..3, bit 0 least significant) is `mask[k] & (mode[k] == field[k])`, where field is the 4-bit condition field `cond_fields[4j+3:4j]` for field index j.
- R2: With `src_vec` = 1, element i reads field index `field_base + i` modulo NUM_FIELDS. With `src_vec` = 0, every element reads field index `field_base`.
- R3: The requested number of nibbles per destination element is 1, 2, 4 or 8 for `src_ew` codes 00, 01, 10 and 11.
- R4: `dst_ew` codes 00, 01, 10 and 11 select element sizes of 64, 8, 16 and 32 bits. The nibbles per element are the smaller of the R3 request and (element bits / 4). For example, code 01 with request 8 gives 2 per element.
- R5: With `dst_vec` = 1 and P nibbles per element, nibble i is placed at bits [4s+3:4s] of register `dst_reg + i/P` (modulo NUM_REGS), where s = i mod P.
- R6: Every register a request touches is written as a whole word: bits not holding a nibble become zero, whatever the register held before. Registers not touched keep their contents.
- R7: With `dst_vec` = 0, all nibbles go into register `dst_reg` at bit offset 4i, and both width codes have no effect.
- R8: After reset, `busy` and `done` are low. A request with VL > 0 keeps `busy` high for exactly VL cycles. `done` is high for the single cycle after the last element, and it coincides with `busy` falling.
- R9: A request with VL = 0 raises `done` in the next cycle, never raises `busy`, and writes no register.
- R10: `start` asserted while `busy` is high is ignored: the running request's results are unchanged.
- R11: `rd_data` returns the register addressed by `rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a request (accepted when idle) |
| vl | input | VLW | Element count, 0..MAX_VL |
| src_vec | input | 1 | Field index steps per element when 1 |
| dst_vec | input | 1 | Results spread over several registers when 1 |
| field_base | input | FW | First condition field index |
| src_ew | input | 2 | Requested nibbles per element code |
| dst_ew | input | 2 | Destination element size code |
| mask | input | 4 | Bit select for the match |
| mode | input | 4 | Expected value per field bit |
| dst_reg | input | AW | First destination register |
| cond_fields | input | 4*NUM_FIELDS | All condition fields, field j at bits 4j+3:4j |
| rd_addr | input | AW | Read port address |
| rd_data | output | XLEN | Read port data, one cycle latency |
| busy | output | 1 | Elements are being processed |
| done | output | 1 | One-cycle completion pulse |

## Verification
Single-element requests with full and partial masks and alternating mode bits separate the mask gating from the equality test. Vector and scalar field sources, including a base that wraps past the last field, show whether the field index steps per element or stays fixed. Every source width code is tried against the wide destination, and each narrow destination code is tried with the largest request, so packing count, slot position and spill into the next register are told apart. A register pre-filled with all ones by a scalar-destination request is then rewritten narrowly, which shows the clearing of unused bits. Zero-length and mid-run start requests show that neither causes a write.

// File: rtl/cpk_pkg.sv
package cpk_pkg;

  localparam int NIB_W = 4;

  // Nibbles that share one destination element for a request.
  function automatic logic [4:0] slots_per_word(input logic [1:0] sew,
                                                input logic [1:0] dew,
                                                input logic       dvec,
                                                input int         xlen);
    int req;
    int cap;
    req = 1 << sew;
    case (dew)
      2'b00:   cap = xlen / NIB_W;
      2'b01:   cap = 8 / NIB_W;
      2'b10:   cap = 16 / NIB_W;
      default: cap = 32 / NIB_W;
    endcase
    if (!dvec) return 5'(xlen / NIB_W);
    return (req < cap) ? 5'(req) : 5'(cap);
  endfunction

endpackage

// File: rtl/cpk_match.sv
module cpk_match #(
  parameter int NUM_FIELDS = 16,
  localparam int FW = $clog2(NUM_FIELDS)
) (
  input  logic [4*NUM_FIELDS-1:0] fields,
  input  logic [FW-1:0]           sel,
  input  logic [3:0]              mask,
  input  logic [3:0]              mode,
  output logic [3:0]              nib
);
  logic [3:0] fld;

  assign fld = fields[4*sel +: 4];

  for (genvar k = 0; k < 4; k++) begin : g_bit
    assign nib[k] = mask[k] & ~(mode[k] ^ fld[k]);
  end

endmodule

// File: rtl/cpk_regfile.sv
module cpk_regfile #(
  parameter int NUM_REGS = 32,
  parameter int XLEN     = 64,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [AW-1:0]   ra,
  output logic [XLEN-1:0] rd
);
  logic [XLEN-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end

endmodule

// File: rtl/cpk_seq.sv
module cpk_seq
  import cpk_pkg::*;
#(
  parameter int NUM_FIELDS = 16,
  parameter int NUM_REGS   = 32,
  parameter int XLEN       = 64,
  parameter int MAX_VL     = 16,
  localparam int FW  = $clog2(NUM_FIELDS),
  localparam int AW  = $clog2(NUM_REGS),
  localparam int VLW = $clog2(MAX_VL + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [VLW-1:0]          vl,
  input  logic                    src_vec,
  input  logic                    dst_vec,
  input  logic [FW-1:0]           field_base,
  input  logic [1:0]              src_ew,
  input  logic [1:0]              dst_ew,
  input  logic [3:0]              mask,
  input  logic [3:0]              mode,
  input  logic [AW-1:0]           dst_reg,
  input  logic [4*NUM_FIELDS-1:0] cond_fields,
  input  logic [3:0]              nib,
  output logic [4*NUM_FIELDS-1:0] fields_q,
  output logic [FW-1:0]           field_sel,
  output logic [3:0]              mask_q,
  output logic [3:0]              mode_q,
  output logic                    wr_en,
  output logic [AW-1:0]           wr_addr,
  output logic [XLEN-1:0]         wr_data,
  output logic                    busy,
  output logic                    done
);
  logic [VLW-1:0]  vl_q;
  logic [VLW-1:0]  elem;
  logic [VLW-1:0]  idx;
  logic [4:0]      slot;
  logic [4:0]      per_q;
  logic            src_vec_q;
  logic [FW-1:0]   base_q;
  logic [AW-1:0]   dst_q;
  logic [XLEN-1:0] acc;
  logic [XLEN-1:0] acc_next;
  logic            last;
  logic            slot_full;

  assign last      = (elem == VLW'(vl_q - 1'b1));
  assign slot_full = (slot == per_q - 5'd1);
  assign field_sel = src_vec_q ? FW'(base_q + FW'(elem)) : base_q;
  assign acc_next  = acc | (XLEN'(nib) << {slot, 2'b00});
  assign wr_en     = busy && (slot_full || last);
  assign wr_addr   = AW'(dst_q + AW'(idx));
  assign wr_data   = acc_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      elem <= '0;
      idx  <= '0;
      slot <= '0;
      acc  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          vl_q      <= (vl > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl;
          per_q     <= slots_per_word(src_ew, dst_ew, dst_vec, XLEN);
          src_vec_q <= src_vec;
          base_q    <= field_base;
          dst_q     <= dst_reg;
          mask_q    <= mask;
          mode_q    <= mode;
          fields_q  <= cond_fields;
          elem      <= '0;
          idx       <= '0;
          slot      <= '0;
          acc       <= '0;
          if (vl == '0) done <= 1'b1;
          else          busy <= 1'b1;
        end
      end else if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
        acc  <= '0;
      end else begin
        elem <= elem + 1'b1;
        if (slot_full) begin
          slot <= '0;
          idx  <= idx + 1'b1;
          acc  <= '0;
        end else begin
          slot <= slot + 5'd1;
          acc  <= acc_next;
        end
      end
    end
  end

endmodule

// File: rtl/cond_pack_unit.sv
module cond_pack_unit #(
  parameter int NUM_FIELDS = 16,
  parameter int NUM_REGS   = 32,
  parameter int XLEN       = 64,
  parameter int MAX_VL     = 16,
  localparam int FW  = $clog2(NUM_FIELDS),
  localparam int AW  = $clog2(NUM_REGS),
  localparam int VLW = $clog2(MAX_VL + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [VLW-1:0]          vl,
  input  logic                    src_vec,
  input  logic                    dst_vec,
  input  logic [FW-1:0]           field_base,
  input  logic [1:0]              src_ew,
  input  logic [1:0]              dst_ew,
  input  logic [3:0]              mask,
  input  logic [3:0]              mode,
  input  logic [AW-1:0]           dst_reg,
  input  logic [4*NUM_FIELDS-1:0] cond_fields,
  input  logic [AW-1:0]           rd_addr,
  output logic [XLEN-1:0]         rd_data,
  output logic                    busy,
  output logic                    done
);
  logic [4*NUM_FIELDS-1:0] fields_q;
  logic [FW-1:0]           field_sel;
  logic [3:0]              mask_q;
  logic [3:0]              mode_q;
  logic [3:0]              nib;
  logic                    wr_en;
  logic [AW-1:0]           wr_addr;
  logic [XLEN-1:0]         wr_data;

  cpk_seq #(
    .NUM_FIELDS(NUM_FIELDS), .NUM_REGS(NUM_REGS),
    .XLEN(XLEN), .MAX_VL(MAX_VL)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .vl(vl),
    .src_vec(src_vec), .dst_vec(dst_vec), .field_base(field_base),
    .src_ew(src_ew), .dst_ew(dst_ew), .mask(mask), .mode(mode),
    .dst_reg(dst_reg), .cond_fields(cond_fields), .nib(nib),
    .fields_q(fields_q), .field_sel(field_sel),
    .mask_q(mask_q), .mode_q(mode_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done)
  );

  cpk_match #(.NUM_FIELDS(NUM_FIELDS)) u_match (
    .fields(fields_q), .sel(field_sel),
    .mask(mask_q), .mode(mode_q), .nib(nib)
  );

  cpk_regfile #(.NUM_REGS(NUM_REGS), .XLEN(XLEN)) u_rf (
    .clk(clk), .we(wr_en), .wa(wr_addr), .wd(wr_data),
    .ra(rd_addr), .rd(rd_data)
  );

endmodule

// File: rtl/cpk_checker.sv
module cpk_checker #(
  parameter int VLW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [VLW-1:0] vl,
  input logic           busy,
  input logic           done,
  input logic           wr_en
);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !(start && vl == '0)) |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_busy_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_launch_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && vl != '0) |=> (busy && !done));

  assert_zero_vl_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && vl == '0) |=> (done && !busy));

  // R5 / R9: the register file is only written while elements run
  assert_write_busy_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);

endmodule

bind cond_pack_unit cpk_checker #(.VLW(VLW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .vl(vl),
  .busy(busy), .done(done), .wr_en(wr_en)
);

// File: tb/sim_cond_pack_unit.sv
module sim_cond_pack_unit;
  localparam int NF = 16;
  localparam int NR = 32;
  localparam int XL = 64;

  typedef struct {
    logic [4:0]  addr;
    logic [63:0] data;
    string       tag;
  } item_t;

  logic        clk = 0;
  logic        rst = 1;
  logic        start = 0;
  logic [4:0]  vl = 0;
  logic        src_vec = 0, dst_vec = 0;
  logic [3:0]  field_base = 0;
  logic [1:0]  src_ew = 0, dst_ew = 0;
  logic [3:0]  mask = 0, mode = 0;
  logic [4:0]  dst_reg = 0;
  logic [63:0] cond_fields;
  logic [4:0]  rd_addr = 0;
  logic [63:0] rd_data;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  bit mon_active = 0;
  item_t q[$];
  logic [63:0] model [NR];
  bit          mvalid [NR];
  logic [3:0]  fld [NF];

  always #2 clk = ~clk;

  cond_pack_unit u0 (
    .clk(clk), .rst(rst), .start(start), .vl(vl),
    .src_vec(src_vec), .dst_vec(dst_vec), .field_base(field_base),
    .src_ew(src_ew), .dst_ew(dst_ew), .mask(mask), .mode(mode),
    .dst_reg(dst_reg), .cond_fields(cond_fields),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: reads back each expected register
  initial begin
    forever begin
      wait (q.size() != 0);
      mon_active = 1;
      while (q.size() != 0) begin
        item_t it;
        it = q.pop_front();
        @(negedge clk) rd_addr = it.addr;
        @(negedge clk);
        check(rd_data === it.data, it.tag, rd_data, it.data);
      end
      mon_active = 0;
    end
  end

  // Driver: computes expectations, runs the request, pushes items
  task automatic run_op(input int n, input bit sv, input bit dv,
                        input int base, input int sew, input int dew,
                        input logic [3:0] mk, input logic [3:0] md,
                        input int dreg, input bit poke, input string tag);
    logic [63:0] words [16];
    int per, req, cap, used, cnt;
    for (int w = 0; w < 16; w++) words[w] = '0;
    req = 1 << sew;
    cap = (dew == 0) ? 16 : (dew == 1) ? 2 : (dew == 2) ? 4 : 8;
    per = dv ? ((req < cap) ? req : cap) : 16;
    for (int i = 0; i < n; i++) begin
      logic [3:0] f, nb;
      f  = fld[sv ? (base + i) % NF : base];
      nb = mk & ~(md ^ f);
      words[i / per] |= 64'(nb) << (4 * (i % per));
    end
    used = (n + per - 1) / per;
    @(negedge clk);
    vl = 5'(n); src_vec = sv; dst_vec = dv; field_base = 4'(base);
    src_ew = 2'(sew); dst_ew = 2'(dew); mask = mk; mode = md;
    dst_reg = 5'(dreg); start = 1;
    @(negedge clk);
    start = 0;
    cnt = 1;
    check(busy === (n != 0), {tag, " R8 busy after start"}, 64'(busy), 64'(n != 0));
    while (done !== 1'b1 && cnt < 100) begin
      if (poke && cnt == 3) begin
        vl = 5'd2; mask = 4'h0; dst_reg = 5'(dreg + 1); start = 1;
      end
      @(negedge clk);
      start = 0;
      cnt++;
    end
    check(cnt == n + 1, {tag, " R8 done timing"}, 64'(cnt), 64'(n + 1));
    @(negedge clk);
    check(done === 1'b0, {tag, " R8 done single pulse"}, 64'(done), 64'd0);
    for (int w = 0; w < used; w++) begin
      int a;
      a = (dreg + w) % NR;
      model[a] = words[w];
      mvalid[a] = 1;
      q.push_back('{addr: 5'(a), data: words[w], tag: tag});
    end
    if (mvalid[(dreg + used) % NR])
      q.push_back('{addr: 5'((dreg + used) % NR), data: model[(dreg + used) % NR],
                    tag: {tag, " R6 neighbour kept"}});
    wait (q.size() == 0 && !mon_active);
  endtask

  initial begin
    for (int j = 0; j < NF; j++) begin
      fld[j] = 4'((j * 7 + 3) % 16);
      cond_fields[4*j +: 4] = fld[j];
    end
    for (int r = 0; r < NR; r++) begin
      mvalid[r] = 0;
      model[r] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R8 reset state", {busy, done}, 64'd0);

    run_op(1, 0, 1, 3, 0, 0, 4'hF, 4'hA, 0, 0, "R1 full mask");
    run_op(1, 0, 1, 5, 0, 0, 4'h5, 4'h3, 1, 0, "R1 partial mask");
    run_op(4, 1, 1, 14, 0, 0, 4'hF, 4'h6, 2, 0, "R2 vector field wrap");
    run_op(4, 0, 1, 9, 1, 0, 4'hF, 4'h1, 8, 0, "R2 scalar field R3");
    run_op(5, 1, 1, 0, 1, 0, 4'hF, 4'h9, 10, 0, "R3 two per element");
    run_op(8, 1, 1, 2, 2, 0, 4'hE, 4'h4, 14, 0, "R3 four per element");
    run_op(16, 1, 1, 1, 3, 0, 4'hF, 4'hC, 16, 0, "R3 eight per element R5");
    run_op(6, 1, 1, 4, 3, 1, 4'hF, 4'h2, 24, 0, "R4 8-bit dest spill");
    run_op(8, 1, 1, 6, 3, 2, 4'hB, 4'h7, 28, 0, "R4 16-bit dest R5");
    run_op(16, 1, 1, 0, 3, 3, 4'hF, 4'h0, 30, 0, "R4 32-bit dest wrap");
    run_op(16, 0, 0, 7, 2, 1, 4'hF, fld[7], 20, 0, "R7 scalar dest all ones");
    run_op(16, 0, 0, 7, 2, 1, 4'hF, fld[7], 21, 0, "R7 scalar dest second");
    run_op(3, 1, 0, 3, 0, 1, 4'hF, 4'h5, 6, 0, "R7 width codes ignored");
    run_op(1, 1, 1, 2, 0, 1, 4'hF, 4'h8, 20, 0, "R6 stale bits cleared");
    run_op(0, 1, 1, 0, 0, 0, 4'hF, 4'h0, 21, 0, "R9 zero length no write");
    run_op(8, 1, 1, 3, 2, 0, 4'hF, 4'hD, 12, 1, "R10 start while busy");
    run_op(2, 1, 1, 11, 0, 0, 4'hF, 4'h3, 4, 0, "R11 read port");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule